// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block translates a 64-bit virtual address into a real address by walking a hierarchy of up to five translation tables held in memory: three region levels (first, second, third), a segment level and a page level. A 64-bit control element names the origin of the top table, the level at which the walk begins and a coarse length limit. The walker fetches one 8-byte entry at a time through a simple read port. Each entry is checked for validity, for the level it claims to be and for the index window it covers. Protection bits are gathered on the way down.

A walk ends in one of three ways. It can end with a real address, either at a page entry or early at a large-frame leaf in a segment or region-third entry. It can end with an interruption code that names the level and the kind of failure. It can also end with a bus-error flag when a memory read fails. The result is presented for exactly one cycle on a done pulse. A new request is taken only while the walker is idle, and the request fields are captured on acceptance.

Top module: `dat_walker`

## Requirements
- R1: `req_ready` is high exactly while no walk is in progress; a request is taken when `req_valid` and `req_ready` are both high, and `req_valid` during a walk has no effect on that walk's reads or result.
- R2: The start level comes from control bits [3:2] (0 segment, 1 region-third, 2 region-second, 3 region-first). The first read address is the origin (control bits [63:12]) times 4096 plus the start-level index times 8. The address indices are region-first VA[63:53], region-second VA[52:42], region-third VA[41:31] and segment VA[30:20].
- R3: When the walk starts below region-first and any index above the start level is nonzero, the walk ends with code 1 and issues no read.
- R4: When the top two bits of the start-level index exceed the control length field (bits [1:0]), the walk ends with no read. The code is 2, 3, 4 or 5 for a start at region-first, region-second, region-third or segment.
- R5: A region-first or region-second entry defines a window on the next index's top two bits, with offset at bits [7:6] and length at bits [1:0]. A value outside that window ends the walk with the next level's code (3 for region-second, 4 for region-third). A region-third entry that is not a leaf applies the same window to the segment index, giving code 5.
- R6: A region or segment entry with bit 5 set, or a page entry with bit 10 set, ends the walk with that level's code (2 to 5, or 6 for the page level).
- R7: A region or segment entry whose type field (bits [3:2]) does not equal its level number ends with code 7. So does a page entry with bit 11 set.
- R8: A segment entry with bit 4 set while the control private bit (bit 7) is set ends with code 7. So does a region-third entry with bit 4 set, private set and `cfg_large_rt` high.
- R9: A full walk ends with code 0 and address {page entry [63:12], VA[11:0]}. Region entries give the next table origin as bits [63:12] times 4096. A segment entry gives the page table origin as bits [63:11] times 2048, and the page index is VA[19:12].
- R10: A segment entry with bit 10 set and `cfg_large_seg` high ends the walk with {entry[63:20], VA[19:0]}. A region-third entry with bit 10 set and `cfg_large_rt` high ends it with {entry[63:31], VA[30:0]}. With the option low, bit 10 is ignored.
- R11: Bit 9 of every entry read is ORed together. A store (mode 1) whose accumulated bit is set ends with code 8, and a fetch (mode 0) of the same tables succeeds.
- R12: An instruction fetch (mode 2) whose leaf has bit 8 set ends with code 8 when `cfg_exec_prot` is high, and succeeds when it is low.
- R13: A read answered with `mem_rsp_err` ends the walk at once. `done_bus_err` is 1, the code is 0, the address is 0 and no further read is issued.
- R14: `done` is a one-cycle pulse per walk, and `mem_rd_valid` is a one-cycle pulse per read with at most one read outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 64 | Virtual address to translate |
| req_ctl | input | 64 | Control element: origin, private bit, start level, length |
| req_mode | input | 2 | Access kind: 0 fetch, 1 store, 2 instruction fetch |
| cfg_large_seg | input | 1 | Enable large frames at segment level |
| cfg_large_rt | input | 1 | Enable large frames at region-third level |
| cfg_exec_prot | input | 1 | Enable execute protection |
| mem_rd_valid | output | 1 | Entry read request pulse |
| mem_rd_addr | output | 64 | Entry read address |
| mem_rsp_valid | input | 1 | Entry read response |
| mem_rsp_data | input | 64 | Entry contents |
| mem_rsp_err | input | 1 | Entry read failed |
| done | output | 1 | Walk finished, result valid this cycle |
| done_code | output | 4 | Interruption code, 0 on success |
| done_paddr | output | 64 | Translated address on success, else 0 |
| done_bus_err | output | 1 | Walk aborted by a read error |

## Verification
The bench builds table trees in a sparse memory model. It checks the exact entry addresses fetched and the number of reads, so a walker that scales the page-table origin by 4096 instead of 2048, or starts at the wrong level, produces a wrong address or read count. Window and length checks are probed at the boundary where only the offset excludes the index, because a walker that compares only against the length would walk on. The format-control bit is set both with its enable high and with it low: a walker that ignores the enable would return a frame address where a page walk was due. Protection is placed high in the tree, not in the leaf, so a walker that keeps only the leaf's bit lets the store through. A read error is injected mid-walk to catch a walker that keeps reading or reports an interruption code instead of the error flag.

// File: rtl/dat_walker_pkg.sv
package dat_walker_pkg;

  localparam int VA_W         = 64;
  localparam int IDX_W        = 11;
  localparam int PX_W         = 8;
  localparam int BX_W         = 12;
  localparam int ENT_SH       = 3;
  localparam int TBL_SH       = 12;
  localparam int PT_SH        = 11;
  localparam int SEG_LO       = PX_W + BX_W;
  localparam int RT_FRAME_LO  = SEG_LO + IDX_W;
  localparam int SEG_FRAME_LO = SEG_LO;
  localparam int CODE_W       = 4;
  localparam int NUM_TBL_LV   = 4;

  typedef enum logic [2:0] {
    LV_SEG  = 3'd0,
    LV_RT   = 3'd1,
    LV_RS   = 3'd2,
    LV_RF   = 3'd3,
    LV_PAGE = 3'd4
  } lvl_e;

  typedef enum logic [CODE_W-1:0] {
    XC_NONE      = 4'd0,
    XC_ASCE_TYPE = 4'd1,
    XC_RF_MISS   = 4'd2,
    XC_RS_MISS   = 4'd3,
    XC_RT_MISS   = 4'd4,
    XC_SEG_MISS  = 4'd5,
    XC_PAGE_MISS = 4'd6,
    XC_SPEC      = 4'd7,
    XC_PROT      = 4'd8
  } xcode_e;

  localparam logic [1:0] ACC_FETCH  = 2'd0;
  localparam logic [1:0] ACC_STORE  = 2'd1;
  localparam logic [1:0] ACC_IFETCH = 2'd2;

  function automatic logic [IDX_W-1:0] index_at(input logic [VA_W-1:0] va, input lvl_e lv);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int l = 0; l < NUM_TBL_LV; l++) begin
      if (int'(lv) == l) r = va[SEG_LO + IDX_W*l +: IDX_W];
    end
    return r;
  endfunction

  function automatic xcode_e miss_code(input lvl_e lv);
    case (lv)
      LV_RF:   return XC_RF_MISS;
      LV_RS:   return XC_RS_MISS;
      LV_RT:   return XC_RT_MISS;
      LV_SEG:  return XC_SEG_MISS;
      default: return XC_PAGE_MISS;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] slot_addr(input logic [VA_W-1:0] base,
                                                input logic [IDX_W-1:0] idx);
    return base + VA_W'({idx, {ENT_SH{1'b0}}});
  endfunction

endpackage

// File: rtl/dat_start_check.sv
module dat_start_check
  import dat_walker_pkg::*;
(
  input  logic [VA_W-1:0]        va,
  input  logic [1:0]             dtype,
  input  logic [1:0]             tlen,
  input  logic [VA_W-1:TBL_SH]   origin,
  output xcode_e                 fault,
  output lvl_e                   start_lv,
  output logic [VA_W-1:0]        first_addr
);

  logic [IDX_W-1:0] idx;
  logic             upper_nz;
  logic             unused_lo;

  assign unused_lo = ^va[SEG_LO-1:0];

  always_comb begin
    start_lv = lvl_e'({1'b0, dtype});
    idx      = index_at(va, start_lv);
    upper_nz = 1'b0;
    for (int l = 0; l < NUM_TBL_LV; l++) begin
      if ((l > int'(dtype)) && (index_at(va, lvl_e'(3'(l))) != '0)) upper_nz = 1'b1;
    end
    if (upper_nz)
      fault = XC_ASCE_TYPE;
    else if (idx[IDX_W-1 -: 2] > tlen)
      fault = miss_code(start_lv);
    else
      fault = XC_NONE;
    first_addr = slot_addr({origin, {TBL_SH{1'b0}}}, idx);
  end

endmodule

// File: rtl/dat_entry_eval.sv
module dat_entry_eval
  import dat_walker_pkg::*;
(
  input  lvl_e             lv,
  input  logic [63:0]      ent,
  input  logic [VA_W-1:0]  va,
  input  logic             priv,
  input  logic             large_seg,
  input  logic             large_rt,
  output xcode_e           fault,
  output logic             leaf,
  output lvl_e             next_lv,
  output logic [VA_W-1:0]  next_addr,
  output logic             prot,
  output logic             iep,
  output logic [VA_W-1:0]  frame
);

  logic [IDX_W-1:0] nidx;
  logic [1:0]       ncoarse;
  logic             win_bad;
  logic             tbl_inv;
  logic             fmt;
  logic             common;

  assign tbl_inv = ent[5];
  assign fmt     = ent[10];
  assign common  = ent[4];

  always_comb begin
    fault     = XC_NONE;
    leaf      = 1'b0;
    next_lv   = LV_PAGE;
    next_addr = '0;
    prot      = ent[9];
    iep       = 1'b0;
    frame     = '0;
    nidx      = '0;
    ncoarse   = '0;
    win_bad   = 1'b0;
    case (lv)
      LV_RF, LV_RS, LV_RT: begin
        next_lv   = lvl_e'(3'(lv) - 3'd1);
        nidx      = index_at(va, next_lv);
        ncoarse   = nidx[IDX_W-1 -: 2];
        win_bad   = (ncoarse < ent[7:6]) || (ncoarse > ent[1:0]);
        next_addr = slot_addr({ent[63:TBL_SH], {TBL_SH{1'b0}}}, nidx);
        if (tbl_inv)
          fault = miss_code(lv);
        else if (ent[3:2] != lv[1:0])
          fault = XC_SPEC;
        else if ((lv == LV_RT) && common && priv && large_rt)
          fault = XC_SPEC;
        else if ((lv == LV_RT) && fmt && large_rt) begin
          leaf  = 1'b1;
          iep   = ent[8];
          frame = {ent[63:RT_FRAME_LO], va[RT_FRAME_LO-1:0]};
        end else if (win_bad)
          fault = miss_code(next_lv);
      end
      LV_SEG: begin
        next_lv   = LV_PAGE;
        next_addr = {ent[63:PT_SH], {PT_SH{1'b0}}} + VA_W'({va[SEG_LO-1:BX_W], {ENT_SH{1'b0}}});
        if (tbl_inv)
          fault = XC_SEG_MISS;
        else if (ent[3:2] != 2'd0)
          fault = XC_SPEC;
        else if (common && priv)
          fault = XC_SPEC;
        else if (fmt && large_seg) begin
          leaf  = 1'b1;
          iep   = ent[8];
          frame = {ent[63:SEG_FRAME_LO], va[SEG_FRAME_LO-1:0]};
        end
      end
      default: begin
        if (ent[10])
          fault = XC_PAGE_MISS;
        else if (ent[11])
          fault = XC_SPEC;
        else begin
          leaf  = 1'b1;
          iep   = ent[8];
          frame = {ent[63:TBL_SH], va[BX_W-1:0]};
        end
      end
    endcase
  end

endmodule

// File: rtl/dat_leaf_check.sv
module dat_leaf_check
  import dat_walker_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       prot_acc,
  input  logic       leaf_iep,
  input  logic       exec_en,
  output xcode_e     fault
);

  always_comb begin
    if ((mode == ACC_STORE) && prot_acc)
      fault = XC_PROT;
    else if ((mode == ACC_IFETCH) && leaf_iep && exec_en)
      fault = XC_PROT;
    else
      fault = XC_NONE;
  end

endmodule

// File: rtl/dat_walker.sv
module dat_walker
  import dat_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [63:0]       req_ctl,
  input  logic [1:0]        req_mode,
  input  logic              cfg_large_seg,
  input  logic              cfg_large_rt,
  input  logic              cfg_exec_prot,
  output logic              mem_rd_valid,
  output logic [VA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              done,
  output logic [CODE_W-1:0] done_code,
  output logic [VA_W-1:0]   done_paddr,
  output logic              done_bus_err
);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_REQ, ST_WAIT} st_e;

  st_e              state_q, state_d;
  logic [VA_W-1:0]  vaddr_q;
  logic [63:0]      ctl_q;
  logic [1:0]       mode_q;
  logic             lg_seg_q, lg_rt_q, exec_q;
  lvl_e             lv_q, lv_d;
  logic [VA_W-1:0]  addr_q, addr_d;
  logic             prot_q, prot_d;
  logic             done_q, done_d;
  xcode_e           code_q, code_d;
  logic [VA_W-1:0]  paddr_q, paddr_d;
  logic             berr_q, berr_d;
  logic             take_req;
  logic             walk_en;

  xcode_e           st_fault;
  lvl_e             st_lv;
  logic [VA_W-1:0]  st_addr;
  xcode_e           ev_fault;
  logic             ev_leaf;
  lvl_e             ev_next_lv;
  logic [VA_W-1:0]  ev_next_addr;
  logic             ev_prot, ev_iep;
  logic [VA_W-1:0]  ev_frame;
  xcode_e           lf_fault;
  logic             unused_ctl;

  assign unused_ctl = ^{ctl_q[TBL_SH-1:8], ctl_q[6:4]};

  assign req_ready    = (state_q == ST_IDLE);
  assign take_req     = req_valid && req_ready;
  assign mem_rd_valid = (state_q == ST_REQ);
  assign mem_rd_addr  = addr_q;
  assign done         = done_q;
  assign done_code    = code_q;
  assign done_paddr   = paddr_q;
  assign done_bus_err = berr_q;

  dat_start_check u_start (
    .va         (vaddr_q),
    .dtype      (ctl_q[3:2]),
    .tlen       (ctl_q[1:0]),
    .origin     (ctl_q[63:TBL_SH]),
    .fault      (st_fault),
    .start_lv   (st_lv),
    .first_addr (st_addr)
  );

  dat_entry_eval u_eval (
    .lv        (lv_q),
    .ent       (mem_rsp_data),
    .va        (vaddr_q),
    .priv      (ctl_q[7]),
    .large_seg (lg_seg_q),
    .large_rt  (lg_rt_q),
    .fault     (ev_fault),
    .leaf      (ev_leaf),
    .next_lv   (ev_next_lv),
    .next_addr (ev_next_addr),
    .prot      (ev_prot),
    .iep       (ev_iep),
    .frame     (ev_frame)
  );

  dat_leaf_check u_leaf (
    .mode     (mode_q),
    .prot_acc (prot_q | ev_prot),
    .leaf_iep (ev_iep),
    .exec_en  (exec_q),
    .fault    (lf_fault)
  );

  always_comb begin
    state_d = state_q;
    lv_d    = lv_q;
    addr_d  = addr_q;
    prot_d  = prot_q;
    done_d  = 1'b0;
    code_d  = XC_NONE;
    paddr_d = '0;
    berr_d  = 1'b0;
    walk_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (take_req) state_d = ST_START;
      end
      ST_START: begin
        walk_en = 1'b1;
        if (st_fault != XC_NONE) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          code_d  = st_fault;
        end else begin
          state_d = ST_REQ;
          lv_d    = st_lv;
          addr_d  = st_addr;
          prot_d  = 1'b0;
        end
      end
      ST_REQ: begin
        state_d = ST_WAIT;
      end
      default: begin
        if (mem_rsp_valid) begin
          walk_en = 1'b1;
          if (mem_rsp_err) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            berr_d  = 1'b1;
          end else if (ev_fault != XC_NONE) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            code_d  = ev_fault;
          end else if (ev_leaf) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            code_d  = lf_fault;
            paddr_d = (lf_fault == XC_NONE) ? ev_frame : '0;
          end else begin
            state_d = ST_REQ;
            lv_d    = ev_next_lv;
            addr_d  = ev_next_addr;
            prot_d  = prot_q | ev_prot;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      vaddr_q  <= '0;
      ctl_q    <= '0;
      mode_q   <= ACC_FETCH;
      lg_seg_q <= 1'b0;
      lg_rt_q  <= 1'b0;
      exec_q   <= 1'b0;
      lv_q     <= LV_SEG;
      addr_q   <= '0;
      prot_q   <= 1'b0;
      done_q   <= 1'b0;
      code_q   <= XC_NONE;
      paddr_q  <= '0;
      berr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      code_q  <= code_d;
      paddr_q <= paddr_d;
      berr_q  <= berr_d;
      if (take_req) begin
        vaddr_q  <= req_vaddr;
        ctl_q    <= req_ctl;
        mode_q   <= req_mode;
        lg_seg_q <= cfg_large_seg;
        lg_rt_q  <= cfg_large_rt;
        exec_q   <= cfg_exec_prot;
      end
      if (walk_en) begin
        lv_q   <= lv_d;
        addr_q <= addr_d;
        prot_q <= prot_d;
      end
    end
  end

endmodule

// File: rtl/dat_walker_chk.sv
module dat_walker_chk
  import dat_walker_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_rd_valid,
  input logic              done,
  input logic [CODE_W-1:0] done_code,
  input logic [VA_W-1:0]   done_paddr,
  input logic              done_bus_err,
  input logic [1:0]        mode_q,
  input logic [VA_W-1:0]   vaddr_q
);

  assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_read_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid);

  assert_idle_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid);

  assert_done_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_bus_err_result_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_bus_err) |-> (done_code == '0 && done_paddr == '0));

  assert_prot_needs_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_code == CODE_W'(XC_PROT)) |-> (mode_q != ACC_FETCH));

  assert_offset_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_bus_err && done_code == '0) |-> (done_paddr[BX_W-1:0] == vaddr_q[BX_W-1:0]));

endmodule

bind dat_walker dat_walker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mem_rd_valid (mem_rd_valid),
  .done         (done),
  .done_code    (done_code),
  .done_paddr   (done_paddr),
  .done_bus_err (done_bus_err),
  .mode_q       (mode_q),
  .vaddr_q      (vaddr_q)
);

// File: tb/dat_walker_tb.sv
module dat_walker_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_vaddr;
  logic [63:0] req_ctl;
  logic [1:0]  req_mode;
  logic        cfg_large_seg, cfg_large_rt, cfg_exec_prot;
  logic        mem_rd_valid;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        mem_rsp_err;
  logic        done;
  logic [3:0]  done_code;
  logic [63:0] done_paddr;
  logic        done_bus_err;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] mem [logic [63:0]];
  logic [63:0] err_addr;
  int          rd_cnt;
  logic [63:0] first_rd;

  logic [3:0]  r_code;
  logic [63:0] r_paddr;
  logic        r_err;

  localparam logic [63:0] BASE_VA = (64'h401 << 53) | (64'h2 << 42) | (64'h3 << 31)
                                  | (64'h4 << 20) | (64'h5 << 12) | 64'h010;
  localparam logic [63:0] BASE_PA = 64'h1234_5010;

  dat_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_ctl(req_ctl), .req_mode(req_mode),
    .cfg_large_seg(cfg_large_seg), .cfg_large_rt(cfg_large_rt), .cfg_exec_prot(cfg_exec_prot),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err), .done(done),
    .done_code(done_code), .done_paddr(done_paddr), .done_bus_err(done_bus_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [63:0] mk_ctl(input logic [63:0] org, input logic priv,
                                         input logic [1:0] dt, input logic [1:0] len);
    return (org << 12) | (64'(priv) << 7) | (64'(dt) << 2) | 64'(len);
  endfunction

  function automatic logic [63:0] mk_reg(input logic [63:0] org, input logic [1:0] off,
                                         input logic [1:0] len, input logic [1:0] tt,
                                         input logic inv, input logic p);
    return (org << 12) | (64'(p) << 9) | (64'(off) << 6) | (64'(inv) << 5)
         | (64'(tt) << 2) | 64'(len);
  endfunction

  function automatic logic [63:0] mk_seg(input logic [63:0] pto, input logic inv,
                                         input logic p, input logic cs);
    return (pto << 11) | (64'(p) << 9) | (64'(inv) << 5) | (64'(cs) << 4);
  endfunction

  function automatic logic [63:0] mk_pte(input logic [63:0] pf, input logic inv,
                                         input logic p, input logic x, input logic z);
    return (pf << 12) | (64'(z) << 11) | (64'(inv) << 10) | (64'(p) << 9) | (64'(x) << 8);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    logic        pend;
    logic [63:0] pend_addr;
    pend = 1'b0;
    pend_addr = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    mem_rsp_err   = 1'b0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      mem_rsp_err   = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_err   = (pend_addr == err_addr);
        mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
      end
      pend = mem_rd_valid;
      pend_addr = mem_rd_addr;
      if (mem_rd_valid) begin
        if (rd_cnt == 0) first_rd = mem_rd_addr;
        rd_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: walk did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic setup_base();
    mem.delete();
    err_addr = 64'hFFFF_FFFF_FFFF_FFF8;
    mem[64'h3008] = mk_reg(64'h2, 2'd0, 2'd3, 2'd3, 1'b0, 1'b0);
    mem[64'h2010] = mk_reg(64'h3, 2'd0, 2'd3, 2'd2, 1'b0, 1'b0);
    mem[64'h3018] = mk_reg(64'h4, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0);
    mem[64'h4020] = mk_seg(64'h10, 1'b0, 1'b0, 1'b0);
    mem[64'h8028] = mk_pte(64'h12345, 1'b0, 1'b0, 1'b0, 1'b0);
    cfg_large_seg = 1'b0;
    cfg_large_rt  = 1'b0;
    cfg_exec_prot = 1'b0;
  endtask

  task automatic launch(input logic [63:0] va, input logic [63:0] ctl, input logic [1:0] md);
    @(negedge clk);
    rd_cnt    = 0;
    first_rd  = '0;
    req_valid = 1'b1;
    req_vaddr = va;
    req_ctl   = ctl;
    req_mode  = md;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    r_code = 4'hF; r_paddr = '1; r_err = 1'bx;
    for (int i = 0; i < 200; i++) begin
      if (done) begin
        r_code = done_code; r_paddr = done_paddr; r_err = done_bus_err;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic walk(input logic [63:0] va, input logic [63:0] ctl, input logic [1:0] md);
    launch(va, ctl, md);
    wait_done();
  endtask

  task automatic t_reset();
    check("R1 ready after reset", 64'(req_ready), 64'd1);
    check("R14 done low after reset", 64'(done), 64'd0);
    check("R14 no read after reset", 64'(mem_rd_valid), 64'd0);
  endtask

  task automatic t_full_walk();
    setup_base();
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R9 full walk code", 64'(r_code), 64'd0);
    check("R9 full walk address", r_paddr, BASE_PA);
    check("R2 first read region-first", first_rd, 64'h3008);
    check("R9 five reads", 64'(rd_cnt), 64'd5);
    check("R13 no bus error", 64'(r_err), 64'd0);
  endtask

  task automatic t_seg_start();
    mem.delete();
    mem[64'h10028] = mk_seg(64'h40, 1'b0, 1'b0, 1'b0);
    mem[64'h20018] = mk_pte(64'h777, 1'b0, 1'b0, 1'b0, 1'b0);
    walk(64'h503ABC, mk_ctl(64'h10, 1'b0, 2'd0, 2'd3), 2'd0);
    check("R2 segment start first read", first_rd, 64'h10028);
    check("R9 page origin times 2048", r_paddr, 64'h777ABC);
    check("R9 segment start reads", 64'(rd_cnt), 64'd2);
  endtask

  task automatic t_rs_start();
    setup_base();
    walk(BASE_VA & ~(64'h7FF << 53), mk_ctl(64'h2, 1'b0, 2'd2, 2'd3), 2'd0);
    check("R2 region-second start first read", first_rd, 64'h2010);
    check("R2 region-second start result", r_paddr, BASE_PA);
    check("R2 region-second start reads", 64'(rd_cnt), 64'd4);
  endtask

  task automatic t_asce_type();
    setup_base();
    walk(BASE_VA, mk_ctl(64'h2, 1'b0, 2'd2, 2'd3), 2'd0);
    check("R3 upper index nonzero code", 64'(r_code), 64'd1);
    check("R3 no read issued", 64'(rd_cnt), 64'd0);
    walk(64'h1 << 31, mk_ctl(64'h10, 1'b0, 2'd0, 2'd3), 2'd0);
    check("R3 segment start with region-third index", 64'(r_code), 64'd1);
  endtask

  task automatic t_length();
    setup_base();
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd1), 2'd0);
    check("R4 region-first length code", 64'(r_code), 64'd2);
    check("R4 no read issued", 64'(rd_cnt), 64'd0);
    walk(64'h200 << 20, mk_ctl(64'h10, 1'b0, 2'd0, 2'd0), 2'd0);
    check("R4 segment length code", 64'(r_code), 64'd5);
  endtask

  task automatic t_window();
    setup_base();
    mem[64'h3008] = mk_reg(64'h2, 2'd1, 2'd3, 2'd3, 1'b0, 1'b0);
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R5 offset window code", 64'(r_code), 64'd3);
    check("R5 stops after one read", 64'(rd_cnt), 64'd1);
    setup_base();
    mem[64'h3018] = mk_reg(64'h4, 2'd1, 2'd3, 2'd1, 1'b0, 1'b0);
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R5 region-third window on segment index", 64'(r_code), 64'd5);
  endtask

  task automatic t_invalid();
    setup_base();
    mem[64'h3018] = mk_reg(64'h4, 2'd0, 2'd3, 2'd1, 1'b1, 1'b0);
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R6 region-third invalid code", 64'(r_code), 64'd4);
    check("R6 region-third invalid reads", 64'(rd_cnt), 64'd3);
    setup_base();
    mem[64'h8028] = mk_pte(64'h12345, 1'b1, 1'b0, 1'b0, 1'b0);
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R6 page invalid code", 64'(r_code), 64'd6);
    check("R6 page invalid address zero", r_paddr, 64'h0);
  endtask

  task automatic t_type();
    setup_base();
    mem[64'h2010] = mk_reg(64'h3, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0);
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R7 type mismatch code", 64'(r_code), 64'd7);
    setup_base();
    mem[64'h8028] = mk_pte(64'h12345, 1'b0, 1'b0, 1'b0, 1'b1);
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R7 page zero bit code", 64'(r_code), 64'd7);
  endtask

  task automatic t_common();
    setup_base();
    mem[64'h4020] = mk_seg(64'h10, 1'b0, 1'b0, 1'b1);
    walk(BASE_VA, mk_ctl(64'h1, 1'b1, 2'd3, 2'd3), 2'd0);
    check("R8 common segment private code", 64'(r_code), 64'd7);
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R8 common segment not private ok", r_paddr, BASE_PA);
    setup_base();
    mem[64'h3018] = mk_reg(64'h4, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0) | (64'h1 << 4);
    cfg_large_rt = 1'b1;
    walk(BASE_VA, mk_ctl(64'h1, 1'b1, 2'd3, 2'd3), 2'd0);
    check("R8 common region private code", 64'(r_code), 64'd7);
    cfg_large_rt = 1'b0;
    walk(BASE_VA, mk_ctl(64'h1, 1'b1, 2'd3, 2'd3), 2'd0);
    check("R8 common region without option ok", r_paddr, BASE_PA);
  endtask

  task automatic t_large();
    setup_base();
    mem[64'h4020] = (64'hABC << 20) | (64'h1 << 10);
    cfg_large_seg = 1'b1;
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R10 segment frame address", r_paddr, 64'hABC0_5010);
    check("R10 segment frame reads", 64'(rd_cnt), 64'd4);
    setup_base();
    mem[64'h4020] = mk_seg(64'h10, 1'b0, 1'b0, 1'b0) | (64'h1 << 10);
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R10 segment format ignored when off", r_paddr, BASE_PA);
    setup_base();
    mem[64'h3018] = (64'h5 << 31) | (64'h1 << 10) | (64'h1 << 2);
    cfg_large_rt = 1'b1;
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R10 region-third frame address", r_paddr, 64'h2_8040_5010);
    check("R10 region-third frame reads", 64'(rd_cnt), 64'd3);
    setup_base();
    mem[64'h3018] = mk_reg(64'h4, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0) | (64'h1 << 10);
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R10 region-third format ignored when off", r_paddr, BASE_PA);
  endtask

  task automatic t_prot();
    setup_base();
    mem[64'h2010] = mk_reg(64'h3, 2'd0, 2'd3, 2'd2, 1'b0, 1'b1);
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd1);
    check("R11 store under upper protection", 64'(r_code), 64'd8);
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R11 fetch under protection ok", r_paddr, BASE_PA);
    setup_base();
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd1);
    check("R11 store without protection ok", 64'(r_code), 64'd0);
  endtask

  task automatic t_exec();
    setup_base();
    mem[64'h8028] = mk_pte(64'h12345, 1'b0, 1'b0, 1'b1, 1'b0);
    cfg_exec_prot = 1'b1;
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd2);
    check("R12 ifetch execute protected", 64'(r_code), 64'd8);
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd1);
    check("R12 store ignores execute bit", r_paddr, BASE_PA);
    cfg_exec_prot = 1'b0;
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd2);
    check("R12 execute protection disabled", r_paddr, BASE_PA);
  endtask

  task automatic t_bus_err();
    setup_base();
    err_addr = 64'h2010;
    walk(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    check("R13 bus error flag", 64'(r_err), 64'd1);
    check("R13 bus error code", 64'(r_code), 64'd0);
    check("R13 reads stop at error", 64'(rd_cnt), 64'd2);
    repeat (4) @(negedge clk);
    check("R13 no read after error", 64'(rd_cnt), 64'd2);
  endtask

  task automatic t_busy_ignore();
    setup_base();
    launch(BASE_VA, mk_ctl(64'h1, 1'b0, 2'd3, 2'd3), 2'd0);
    for (int i = 0; i < 3; i++) begin
      check("R1 not ready while busy", 64'(req_ready), 64'd0);
      req_valid = 1'b1;
      req_vaddr = 64'h0;
      req_ctl   = mk_ctl(64'h10, 1'b0, 2'd0, 2'd3);
      req_mode  = 2'd1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_done();
    check("R1 busy request ignored result", r_paddr, BASE_PA);
    check("R1 busy request ignored reads", 64'(rd_cnt), 64'd5);
    @(negedge clk);
    check("R14 done single cycle", 64'(done), 64'd0);
    check("R1 ready after walk", 64'(req_ready), 64'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_ctl   = '0;
    req_mode  = 2'd0;
    cfg_large_seg = 1'b0;
    cfg_large_rt  = 1'b0;
    cfg_exec_prot = 1'b0;
    err_addr = 64'hFFFF_FFFF_FFFF_FFF8;
    rd_cnt = 0;
    first_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_walk();
    t_seg_start();
    t_rs_start();
    t_asce_type();
    t_length();
    t_window();
    t_invalid();
    t_type();
    t_common();
    t_large();
    t_prot();
    t_exec();
    t_bus_err();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule